// File: doc/BRIEF.md
# Wide-Target Branch and Link Unit

This block owns the program counter of a small core whose register-file memory is larger than a 9-bit operand field can address. Each cycle it takes one decoded operation (step, jump, or jump-and-link), both 9-bit operand fields, an immediate selector, the value read from the source register, and one mode bit. In other instructions that mode bit would ask for a carry write. Here it selects the wide addressing mode. The block computes the next PC and, for jump-and-link, a register write-back request.

With the mode bit clear, jumps behave as on a core limited to 512 words. The target is the source field or the low 9 bits of the source register, and the upper PC bits are cleared. A call writes only the low 9 bits of the return PC to the register named by the destination field. With the mode bit set, an immediate target is the destination field placed above the source field, and an indirect target uses the full PC width of the register. A call stores the whole return PC in one link register, whose address is fixed when the block is built. That link register is overwritten by every wide call, so nesting is left to software.

Top module: `bl_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the PC is 0 and no write-back is requested.
- R2: Op code 2'b00 (step), and the reserved code 2'b11, advance the PC by one, wrapping to 0 past the top of the PC_W-bit range, with no write-back.
- R3: Op code 2'b01 (jump) with the mode bit clear loads the PC from the source field when the immediate selector is 1, or from bits [8:0] of the register data when it is 0. PC bits above bit 8 become 0.
- R4: Op code 2'b10 (call) with the mode bit clear takes the target given by R3. It writes (PC+1) bits [8:0], zero-extended, to the register address given by the destination field.
- R5: With the mode bit set and the immediate selector at 1, a jump or call target is {destination, source} (destination in bits [17:9]), truncated to PC_W bits.
- R6: With the mode bit set and the immediate selector at 0, a jump or call target is register data bits [PC_W-1:0].
- R7: A call with the mode bit set writes the full PC+1, wrapped at PC_W bits and zero-extended, to LINK_ADDR, whatever the destination field holds. Each such call overwrites the previous value.
- R8: Write-back is requested only for calls. Its enable, address and data are presented in the cycle after the call and last one cycle.
- R9: When the stall input is high, the PC holds, the operation is ignored and no write-back is requested in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold the PC and drop this cycle's operation |
| op | input | 2 | 00 step, 01 jump, 10 call, 11 step |
| ext_mode | input | 1 | Repurposed carry-write bit; 1 selects wide addressing |
| imm_sel | input | 1 | 1: source field is the target; 0: register data is the target |
| src_field | input | 9 | Source operand field |
| dst_field | input | 9 | Destination operand field |
| src_rdata | input | DATA_W | Data read from the register named by the source field |
| pc | output | PC_W | Current program counter |
| wb_en | output | 1 | Register write-back request |
| wb_addr | output | 9 | Write-back register address |
| wb_data | output | DATA_W | Write-back data (return address) |

## Verification
Every result is registered once. The PC and the write-back fields for an operation presented before a rising edge both appear right after that edge, and write-back lasts one cycle only. Each test task drives its inputs away from the edge, waits for exactly one rising edge, and samples one time unit later. It compares the outputs with a PC model kept in the bench. The step that follows each call confirms that the write-back request has dropped by that point.

// File: rtl/bl_pkg.sv
package bl_pkg;
    localparam int FIELD_W = 9;
    localparam int WIDE_W  = 2 * FIELD_W;

    typedef enum logic [1:0] {
        OP_STEP = 2'b00,
        OP_JUMP = 2'b01,
        OP_CALL = 2'b10,
        OP_RSVD = 2'b11
    } bl_op_e;
endpackage

// File: rtl/bl_target.sv
module bl_target
    import bl_pkg::*;
#(
    parameter int PC_W   = 10,
    parameter int DATA_W = 32
) (
    input  logic               ext_mode,
    input  logic               imm_sel,
    input  logic [FIELD_W-1:0] src_field,
    input  logic [FIELD_W-1:0] dst_field,
    input  logic [DATA_W-1:0]  src_rdata,
    output logic [PC_W-1:0]    target
);
    logic [FIELD_W-1:0] narrow;
    logic [WIDE_W-1:0]  wide_imm;

    always_comb begin
        narrow   = imm_sel ? src_field : src_rdata[FIELD_W-1:0];
        wide_imm = {dst_field, src_field};
        if (!ext_mode) begin
            target = PC_W'(narrow);
        end else if (imm_sel) begin
            target = PC_W'(wide_imm);
        end else begin
            target = PC_W'(src_rdata);
        end
    end
endmodule

// File: rtl/bl_link.sv
module bl_link
    import bl_pkg::*;
#(
    parameter int                 PC_W      = 10,
    parameter int                 DATA_W    = 32,
    parameter logic [FIELD_W-1:0] LINK_ADDR = 9'h1EF
) (
    input  logic [PC_W-1:0]    cur_pc,
    input  logic               ext_mode,
    input  logic [FIELD_W-1:0] dst_field,
    output logic [FIELD_W-1:0] link_addr,
    output logic [DATA_W-1:0]  link_data
);
    logic [PC_W-1:0] ret_pc;

    always_comb begin
        ret_pc = cur_pc + PC_W'(1);
        if (ext_mode) begin
            link_addr = LINK_ADDR;
            link_data = DATA_W'(ret_pc);
        end else begin
            link_addr = dst_field;
            link_data = DATA_W'(ret_pc[FIELD_W-1:0]);
        end
    end
endmodule

// File: rtl/bl_unit.sv
module bl_unit
    import bl_pkg::*;
#(
    parameter int                 PC_W      = 10,
    parameter int                 DATA_W    = 32,
    parameter logic [FIELD_W-1:0] LINK_ADDR = 9'h1EF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic [1:0]         op,
    input  logic               ext_mode,
    input  logic               imm_sel,
    input  logic [FIELD_W-1:0] src_field,
    input  logic [FIELD_W-1:0] dst_field,
    input  logic [DATA_W-1:0]  src_rdata,
    output logic [PC_W-1:0]    pc,
    output logic               wb_en,
    output logic [FIELD_W-1:0] wb_addr,
    output logic [DATA_W-1:0]  wb_data
);
    typedef struct packed {
        logic [PC_W-1:0]    pc;
        logic               wb_en;
        logic [FIELD_W-1:0] wb_addr;
        logic [DATA_W-1:0]  wb_data;
    } bl_state_t;

    bl_state_t          st_d, st_q;
    logic [PC_W-1:0]    target;
    logic [FIELD_W-1:0] link_addr;
    logic [DATA_W-1:0]  link_data;
    bl_op_e             op_e;

    assign op_e = bl_op_e'(op);

    bl_target #(.PC_W(PC_W), .DATA_W(DATA_W)) target_i (
        .ext_mode (ext_mode),
        .imm_sel  (imm_sel),
        .src_field(src_field),
        .dst_field(dst_field),
        .src_rdata(src_rdata),
        .target   (target)
    );

    bl_link #(.PC_W(PC_W), .DATA_W(DATA_W), .LINK_ADDR(LINK_ADDR)) link_i (
        .cur_pc   (st_q.pc),
        .ext_mode (ext_mode),
        .dst_field(dst_field),
        .link_addr(link_addr),
        .link_data(link_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wb_en = 1'b0;
        if (!stall) begin
            unique case (op_e)
                OP_JUMP: st_d.pc = target;
                OP_CALL: begin
                    st_d.pc      = target;
                    st_d.wb_en   = 1'b1;
                    st_d.wb_addr = link_addr;
                    st_d.wb_data = link_data;
                end
                default: st_d.pc = st_q.pc + PC_W'(1);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc      = st_q.pc;
    assign wb_en   = st_q.wb_en;
    assign wb_addr = st_q.wb_addr;
    assign wb_data = st_q.wb_data;
endmodule

// File: rtl/bl_unit_chk.sv
module bl_unit_chk
    import bl_pkg::*;
#(
    parameter int                 PC_W      = 10,
    parameter int                 DATA_W    = 32,
    parameter logic [FIELD_W-1:0] LINK_ADDR = 9'h1EF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stall,
    input logic [1:0]         op,
    input logic               ext_mode,
    input logic               imm_sel,
    input logic [FIELD_W-1:0] src_field,
    input logic [FIELD_W-1:0] dst_field,
    input logic [DATA_W-1:0]  src_rdata,
    input logic [PC_W-1:0]    pc,
    input logic               wb_en,
    input logic [FIELD_W-1:0] wb_addr,
    input logic [DATA_W-1:0]  wb_data
);
    logic [PC_W-1:0] wide_tgt;
    assign wide_tgt = PC_W'({dst_field, src_field});

    assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0 && !wb_en));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && (op == 2'b00 || op == 2'b11)) |=> (pc == $past(pc) + PC_W'(1) && !wb_en));

    assert_legacy_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !ext_mode && (op == 2'b01 || op == 2'b10)) |=> (pc >> FIELD_W) == '0);

    assert_legacy_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !ext_mode && op == 2'b10) |=>
            (wb_addr == $past(dst_field) && (wb_data >> FIELD_W) == '0));

    assert_wide_imm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && ext_mode && imm_sel && (op == 2'b01 || op == 2'b10)) |=> pc == $past(wide_tgt));

    assert_wide_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && ext_mode && op == 2'b10) |=>
            (wb_en && wb_addr == LINK_ADDR && wb_data == DATA_W'($past(pc) + PC_W'(1))));

    assert_wb_only_call_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || op != 2'b10) |=> !wb_en);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc));
endmodule

bind bl_unit bl_unit_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .LINK_ADDR(LINK_ADDR)) chk_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .op(op), .ext_mode(ext_mode),
    .imm_sel(imm_sel), .src_field(src_field), .dst_field(dst_field),
    .src_rdata(src_rdata), .pc(pc), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data)
);

// File: tb/bl_unit_tb.sv
module bl_unit_tb_top;
    localparam int         PC_W   = 10;
    localparam int         DATA_W = 32;
    localparam logic [8:0] LINK   = 9'h1EF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              stall = 1'b0;
    logic [1:0]        op = 2'b00;
    logic              ext_mode = 1'b0;
    logic              imm_sel = 1'b0;
    logic [8:0]        src_field = '0;
    logic [8:0]        dst_field = '0;
    logic [DATA_W-1:0] src_rdata = '0;
    logic [PC_W-1:0]   pc;
    logic              wb_en;
    logic [8:0]        wb_addr;
    logic [DATA_W-1:0] wb_data;

    int checks = 0;
    int errors = 0;
    logic [PC_W-1:0] model_pc = '0;

    always #2 clk = ~clk;

    bl_unit #(.PC_W(PC_W), .DATA_W(DATA_W), .LINK_ADDR(LINK)) dut_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .op(op), .ext_mode(ext_mode),
        .imm_sel(imm_sel), .src_field(src_field), .dst_field(dst_field),
        .src_rdata(src_rdata), .pc(pc), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] o, input logic m, input logic im,
                         input logic [8:0] s, input logic [8:0] d,
                         input logic [DATA_W-1:0] r, input logic st);
        op = o; ext_mode = m; imm_sel = im; src_field = s; dst_field = d;
        src_rdata = r; stall = st;
        @(posedge clk);
        #1;
        stall = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pc", 64'(pc), 0);
        check("R1 wb_en", 64'(wb_en), 0);
        rst_n = 1'b1;
        issue(2'b00, 0, 0, 0, 0, 0, 0);
        model_pc = 1;
        check("R1 first step", 64'(pc), 1);
    endtask

    task automatic t_step();
        issue(2'b00, 0, 0, 9'h1FF, 9'h1FF, '1, 0);
        check("R2 step", 64'(pc), 2);
        check("R2 no wb", 64'(wb_en), 0);
        issue(2'b11, 1, 1, 9'h0AA, 9'h001, 0, 0);
        check("R2 reserved steps", 64'(pc), 3);
        model_pc = 3;
    endtask

    task automatic t_legacy_jump();
        issue(2'b01, 0, 1, 9'h1F0, 9'h155, 32'hFFFF_FFFF, 0);
        check("R3 imm jump", 64'(pc), 64'h1F0);
        issue(2'b01, 0, 0, 9'h000, 9'h1FF, 32'h0000_03A5, 0);
        check("R3 indirect low9", 64'(pc), 64'h1A5);
        check("R3 no wb", 64'(wb_en), 0);
    endtask

    task automatic t_legacy_call();
        issue(2'b10, 0, 1, 9'h050, 9'h023, 0, 0);
        check("R4 target", 64'(pc), 64'h050);
        check("R8 wb_en", 64'(wb_en), 1);
        check("R4 wb_addr", 64'(wb_addr), 64'h023);
        check("R4 wb_data", 64'(wb_data), 64'h1A6);
        issue(2'b00, 0, 0, 0, 0, 0, 0);
        check("R8 wb one cycle", 64'(wb_en), 0);
        issue(2'b01, 1, 1, 9'h0F0, 9'h001, 0, 0);
        check("R5 wide jump", 64'(pc), 64'h2F0);
        issue(2'b10, 0, 1, 9'h010, 9'h044, 0, 0);
        check("R3 upper cleared", 64'(pc), 64'h010);
        check("R4 low9 of 0x2F1", 64'(wb_data), 64'h0F1);
        check("R4 addr", 64'(wb_addr), 64'h044);
    endtask

    task automatic t_wide();
        issue(2'b01, 1, 1, 9'h001, 9'h1FF, 0, 0);
        check("R5 truncated", 64'(pc), 64'h201);
        issue(2'b10, 1, 1, 9'h100, 9'h001, 0, 0);
        check("R5 call target", 64'(pc), 64'h300);
        check("R7 link addr", 64'(wb_addr), 64'(LINK));
        check("R7 link data", 64'(wb_data), 64'h202);
        check("R8 wb_en", 64'(wb_en), 1);
        issue(2'b00, 0, 0, 0, 0, 0, 0);
        check("R8 wb dropped", 64'(wb_en), 0);
        check("R2 pc", 64'(pc), 64'h301);
        issue(2'b10, 1, 1, 9'h010, 9'h000, 0, 0);
        check("R7 overwrite data", 64'(wb_data), 64'h302);
        check("R7 overwrite addr", 64'(wb_addr), 64'(LINK));
        issue(2'b01, 1, 0, 9'h000, 9'h000, 32'h0000_0202, 0);
        check("R6 indirect return", 64'(pc), 64'h202);
        issue(2'b01, 1, 0, 9'h000, 9'h000, 32'hFFFF_F3FF, 0);
        check("R6 full width", 64'(pc), 64'h3FF);
        issue(2'b00, 0, 0, 0, 0, 0, 0);
        check("R2 wrap", 64'(pc), 0);
        issue(2'b10, 1, 0, 9'h000, 9'h000, 32'h0000_0123, 0);
        check("R6 call indirect", 64'(pc), 64'h123);
        check("R7 data from 0", 64'(wb_data), 64'h001);
    endtask

    task automatic t_stall();
        issue(2'b10, 1, 1, 9'h055, 9'h001, 0, 1);
        check("R9 pc held", 64'(pc), 64'h123);
        check("R9 no wb", 64'(wb_en), 0);
        issue(2'b00, 0, 0, 0, 0, 0, 0);
        check("R9 resume", 64'(pc), 64'h124);
    endtask

    initial begin
        #9;
        t_reset();
        t_step();
        t_legacy_jump();
        t_legacy_call();
        t_wide();
        t_stall();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule